// File: doc/BRIEF.md
# Self-Triggered Pixel Reset Sequencer

The block is the digital controller for one channel of a charge-integrating pixel front-end. This front-end has no resistive feedback, so charge stays on the input until it receives an explicit reset pulse. The block watches four trigger sources and turns each accepted trigger into a sequence of ADC sample-hold requests and a front-end reset pulse:

- the channel's own discriminator;
- an external trigger;
- a cross-trigger raised by a neighbouring channel;
- a periodic timer.

A periodic trigger only drains the front-end and is never digitized. The other three triggers lead to one or more digitizations, each emitted downstream as a hit word.

Three integration styles are selectable:

- **Normal:** one sample, then reset.
- **Fixed-count integration:** a programmed number of samples spaced one sample interval apart, then reset.
- **Settle-detect integration:** samples continue until two consecutive codes agree within a tolerance, or until a sample cap is reached.

The reset pulse starts the clock after the final conversion completes. This keeps the charge lost between hold and reset recovery small.

Top module: `pixel_reset_seq`

## Requirements
- R1: A discriminator hit accepted while idle raises hold_req in the next cycle. After adc_done the block emits one word with cause 00 and then pulses fe_reset. hold_req drops the cycle after adc_done.
- R2: An external trigger alone produces the same sequence with cause 01.
- R3: A cross-trigger alone produces the same sequence with cause 10.
- R4: A periodic trigger alone pulses fe_reset from the next cycle, with no hold_req and no word.
- R5: When several triggers arrive in the same cycle, the priority is hit over external over cross over periodic. A periodic trigger together with any sampling trigger causes no extra reset.
- R6: With mode 01, the channel takes max(n_samples,1) samples. Consecutive rises of hold_req are SAMPLE_INT (20) clocks apart, and the reset follows only the last sample.
- R7: With mode 10, sampling stops once two consecutive codes differ by no more than settle_tol. At least two samples are always taken.
- R8: With mode 10, if the codes never settle, sampling stops after max(max_samples,1) samples. The last word then carries cause 11.
- R9: fe_reset rises the cycle after the final adc_done and lasts max(rst_width,1) clocks. hold_req is never high while fe_reset is high.
- R10: The word holds the channel ID in bits [31:26], the cause in [25:24], the timestamp at conversion in [23:8] and the code in [7:0]. word_data stays stable while word_valid is high and word_ready is low. No new hold_req starts while a word is still pending.
- R11: Triggers that arrive while a sample, wait or reset sequence is in progress have no effect.
- R12: While chan_en is low, fe_reset is held high and all triggers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; low holds the front-end in reset |
| mode | input | 2 | 00 normal, 01 fixed-count, 10 settle-detect, 11 normal |
| n_samples | input | 4 | Sample count for fixed-count mode |
| max_samples | input | 4 | Sample cap for settle-detect mode |
| settle_tol | input | 8 | Settle tolerance in ADC codes |
| rst_width | input | 4 | Reset pulse width in clocks (0 acts as 1) |
| hit_in | input | 1 | Discriminator trigger |
| ext_trig | input | 1 | External trigger |
| cross_trig | input | 1 | Cross-trigger from other channels |
| periodic_trig | input | 1 | Periodic drain request |
| timestamp | input | 16 | Free-running time reference |
| hold_req | output | 1 | Sample-hold request to the ADC, held until adc_done |
| adc_done | input | 1 | Conversion complete |
| adc_code | input | 8 | Converted value, valid with adc_done |
| fe_reset | output | 1 | Front-end reset |
| word_valid | output | 1 | Hit word valid |
| word_ready | input | 1 | Downstream buffer ready |
| word_data | output | 32 | Hit word |

## Verification
The trigger inputs are driven singly and in combinations. Single triggers separate the cause codes. Simultaneous triggers show the priority, and that a periodic request coinciding with a sampling trigger adds no reset. ADC code ramps of different lengths are fed under settle-detect mode with a tight and a loose tolerance. These runs show whether the settle point, the minimum of two samples and the forced cap are each honoured. Fixed-count runs with counts of zero and three check the sample spacing and where the reset falls. Directed cases then hold the buffer not-ready, inject triggers mid-sequence and drop the enable.

// File: rtl/pixel_reset_seq.sv
module pixel_reset_seq #(
  parameter int CHAN_ID    = 5,
  parameter int CHAN_W     = 6,
  parameter int ADC_W      = 8,
  parameter int TS_W       = 16,
  parameter int SAMPLE_INT = 20,
  parameter int CNT_W      = 4,
  parameter int RW_W       = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           chan_en,
  input  logic [1:0]                     mode,
  input  logic [CNT_W-1:0]               n_samples,
  input  logic [CNT_W-1:0]               max_samples,
  input  logic [ADC_W-1:0]               settle_tol,
  input  logic [RW_W-1:0]                rst_width,
  input  logic                           hit_in,
  input  logic                           ext_trig,
  input  logic                           cross_trig,
  input  logic                           periodic_trig,
  input  logic [TS_W-1:0]                timestamp,
  output logic                           hold_req,
  input  logic                           adc_done,
  input  logic [ADC_W-1:0]               adc_code,
  output logic                           fe_reset,
  output logic                           word_valid,
  input  logic                           word_ready,
  output logic [CHAN_W+2+TS_W+ADC_W-1:0] word_data
);
  localparam int WORD_W = CHAN_W + 2 + TS_W + ADC_W;
  localparam int ITV_W  = $clog2(SAMPLE_INT + 1);
  localparam logic [ITV_W-1:0] ITV_LAST = ITV_W'(SAMPLE_INT - 1);
  localparam logic [CNT_W:0]   ONE      = {{CNT_W{1'b0}}, 1'b1};

  typedef enum logic [1:0] {S_IDLE, S_SAMP, S_WAIT, S_RST} state_t;

  state_t             state;
  logic [1:0]         cause;
  logic [CNT_W-1:0]   cnt;
  logic [ADC_W-1:0]   prev;
  logic [ITV_W-1:0]   itv;
  logic [RW_W-1:0]    rcnt;

  logic               samp_trig, accept, settled, forced, last_samp, rst_end;
  logic [1:0]         cause_sel, wcause;
  logic [CNT_W:0]     cnt_nx, n_eff, max_eff;
  logic [ADC_W-1:0]   diff;

  assign samp_trig = hit_in | ext_trig | cross_trig;
  assign cause_sel = hit_in ? 2'b00 : (ext_trig ? 2'b01 : 2'b10);
  assign accept    = (state == S_IDLE) && chan_en && !word_valid;

  assign cnt_nx  = {1'b0, cnt} + ONE;
  assign n_eff   = (n_samples == '0)   ? ONE : {1'b0, n_samples};
  assign max_eff = (max_samples == '0) ? ONE : {1'b0, max_samples};
  assign diff    = (adc_code >= prev) ? adc_code - prev : prev - adc_code;
  assign settled = (cnt != '0) && (diff <= settle_tol);
  assign forced  = (mode == 2'b10) && !settled && (cnt_nx >= max_eff);
  assign wcause  = forced ? 2'b11 : cause;

  always_comb begin
    case (mode)
      2'b01:   last_samp = cnt_nx >= n_eff;
      2'b10:   last_samp = settled || (cnt_nx >= max_eff);
      default: last_samp = 1'b1;
    endcase
  end

  assign rst_end  = ({1'b0, rcnt} + {{RW_W{1'b0}}, 1'b1}) >= {1'b0, rst_width};
  assign hold_req = (state == S_SAMP) && chan_en;
  assign fe_reset = (state == S_RST) || !chan_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cause      <= 2'b00;
      cnt        <= '0;
      prev       <= '0;
      itv        <= '0;
      rcnt       <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      if (word_valid && word_ready) word_valid <= 1'b0;
      if (itv != ITV_LAST) itv <= itv + 1'b1;
      if (!chan_en) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: begin
            if (accept && samp_trig) begin
              state <= S_SAMP;
              cause <= cause_sel;
              cnt   <= '0;
              itv   <= '0;
            end else if (accept && periodic_trig) begin
              state <= S_RST;
              rcnt  <= '0;
            end
          end
          S_SAMP: begin
            if (adc_done) begin
              prev       <= adc_code;
              cnt        <= cnt_nx[CNT_W-1:0];
              word_valid <= 1'b1;
              word_data  <= {CHAN_W'(CHAN_ID), wcause, timestamp, adc_code};
              if (last_samp) begin
                state <= S_RST;
                rcnt  <= '0;
              end else begin
                state <= S_WAIT;
              end
            end
          end
          S_WAIT: begin
            if (itv == ITV_LAST && !word_valid) begin
              state <= S_SAMP;
              itv   <= '0;
            end
          end
          S_RST: begin
            if (rst_end) state <= S_IDLE;
            else         rcnt  <= rcnt + 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pixel_reset_seq_chk.sv
module pixel_reset_seq_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chan_en,
  input logic              hold_req,
  input logic              adc_done,
  input logic              fe_reset,
  input logic              word_valid,
  input logic              word_ready,
  input logic [WORD_W-1:0] word_data
);
  AST_DISABLED_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> fe_reset && !hold_req);                                    // R12
  AST_HOLD_NOT_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    fe_reset |-> !hold_req);                                                // R9
  AST_HOLD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_req && adc_done |=> !hold_req);                                    // R1
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_ready |=> word_valid && $stable(word_data));        // R10
  AST_NO_HOLD_WITH_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_req) |-> !word_valid);                                       // R10
endmodule

bind pixel_reset_seq pixel_reset_seq_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .hold_req(hold_req),
  .adc_done(adc_done), .fe_reset(fe_reset), .word_valid(word_valid),
  .word_ready(word_ready), .word_data(word_data)
);

// File: tb/pixel_reset_seq_test.sv
module pixel_reset_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic [3:0]  n_samples = 4'd1, max_samples = 4'd1, rst_width = 4'd1;
  logic [7:0]  settle_tol = 8'd0;
  logic        hit_in = 1'b0, ext_trig = 1'b0, cross_trig = 1'b0, periodic_trig = 1'b0;
  logic        hold_req, adc_done = 1'b0, fe_reset, word_valid, word_ready = 1'b1;
  logic [7:0]  adc_code = 8'd0;
  logic [31:0] word_data;
  int          cyc = 0;
  logic [15:0] timestamp;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign timestamp = cyc[15:0];

  pixel_reset_seq uut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .mode(mode),
    .n_samples(n_samples), .max_samples(max_samples), .settle_tol(settle_tol),
    .rst_width(rst_width), .hit_in(hit_in), .ext_trig(ext_trig),
    .cross_trig(cross_trig), .periodic_trig(periodic_trig), .timestamp(timestamp),
    .hold_req(hold_req), .adc_done(adc_done), .adc_code(adc_code),
    .fe_reset(fe_reset), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data)
  );

  function automatic logic [7:0] code_of(int k, int flat);
    int kk = (k < flat) ? k : flat;
    return 8'(10 + 20 * kk);
  endfunction

  int k_smp = 0, cur_flat = 0;
  always @(posedge clk) begin
    adc_done <= hold_req && !adc_done;
    if (hold_req && !adc_done) begin
      adc_code <= code_of(k_smp, cur_flat);
      k_smp    <= k_smp + 1;
    end
  end

  int holds, words, rst_pulses, rst_len, rst_start, last_rise, prev_rise, done_cyc;
  logic [7:0]  last_code;
  logic [15:0] last_ts;
  logic [31:0] last_word;
  logic        hold_q = 1'b0, rst_q = 1'b0;

  always @(negedge clk) begin
    if (hold_req && !hold_q) begin
      holds++; prev_rise = last_rise; last_rise = cyc;
    end
    if (adc_done) begin
      done_cyc = cyc; last_code = adc_code; last_ts = cyc[15:0];
    end
    if (word_valid && word_ready) begin
      words++; last_word = word_data;
    end
    if (fe_reset && !rst_q) begin
      rst_pulses++; rst_start = cyc; rst_len = 1;
    end else if (fe_reset) begin
      rst_len++;
    end
    hold_q = hold_req;
    rst_q  = fe_reset;
  end

  int total = 0, fails = 0, trig_cyc = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_mon(input int flat);
    holds = 0; words = 0; rst_pulses = 0; rst_len = 0; rst_start = -1;
    last_rise = -1; prev_rise = -1; done_cyc = -1; last_word = '0;
    k_smp = 0; cur_flat = flat;
  endtask

  task automatic fire(input logic [3:0] t);
    @(posedge clk); #1;
    {periodic_trig, cross_trig, ext_trig, hit_in} = t;
    trig_cyc = cyc;
    @(posedge clk); #1;
    {periodic_trig, cross_trig, ext_trig, hit_in} = 4'b0000;
  endtask

  // trig, mode, n, tol, max, flat, rw, holds, cause
  localparam logic [34:0] VECS [12] = '{
    {3'd0, 2'd0, 4'd1, 8'd0,  4'd1, 4'd0, 4'd3, 4'd1, 2'd0},
    {3'd1, 2'd0, 4'd1, 8'd0,  4'd1, 4'd0, 4'd1, 4'd1, 2'd1},
    {3'd2, 2'd0, 4'd1, 8'd0,  4'd1, 4'd0, 4'd0, 4'd1, 2'd2},
    {3'd3, 2'd0, 4'd1, 8'd0,  4'd1, 4'd0, 4'd4, 4'd0, 2'd0},
    {3'd4, 2'd0, 4'd1, 8'd0,  4'd1, 4'd0, 4'd2, 4'd1, 2'd0},
    {3'd5, 2'd0, 4'd1, 8'd0,  4'd1, 4'd0, 4'd2, 4'd1, 2'd1},
    {3'd0, 2'd1, 4'd3, 8'd0,  4'd1, 4'd0, 4'd2, 4'd3, 2'd0},
    {3'd0, 2'd1, 4'd0, 8'd0,  4'd1, 4'd0, 4'd2, 4'd1, 2'd0},
    {3'd1, 2'd2, 4'd1, 8'd5,  4'd8, 4'd2, 4'd2, 4'd4, 2'd1},
    {3'd2, 2'd2, 4'd1, 8'd20, 4'd8, 4'd5, 4'd2, 4'd2, 2'd2},
    {3'd0, 2'd2, 4'd1, 8'd5,  4'd4, 4'd9, 4'd5, 4'd4, 2'd3},
    {3'd0, 2'd2, 4'd1, 8'd5,  4'd8, 4'd0, 4'd2, 4'd2, 2'd0}
  };

  function automatic logic [3:0] trig_bits(input logic [2:0] t);
    case (t)
      3'd0: return 4'b0001;
      3'd1: return 4'b0010;
      3'd2: return 4'b0100;
      3'd3: return 4'b1000;
      3'd4: return 4'b1111;
      default: return 4'b1010;
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    clr_mon(0);
    repeat (3) @(posedge clk);
    #1;
    chk("RST hold_req low in reset", int'(hold_req), 0);
    chk("RST word_valid low in reset", int'(word_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("RST fe_reset low when enabled idle", int'(fe_reset), 0);

    for (int i = 0; i < 12; i++) begin
      logic [2:0] t; logic [1:0] md, ec; logic [3:0] nn, mx, fl, rw, eh; logic [7:0] tl;
      int rw_eff;
      {t, md, nn, tl, mx, fl, rw, eh, ec} = VECS[i];
      mode = md; n_samples = nn; settle_tol = tl; max_samples = mx; rst_width = rw;
      rw_eff = (rw == 0) ? 1 : int'(rw);
      clr_mon(int'(fl));
      fire(trig_bits(t));
      repeat (220) @(posedge clk);
      #1;
      chk($sformatf("R1 R6 R7 R8 vec%0d hold count", i), holds, int'(eh));
      chk($sformatf("R10 vec%0d word count", i), words, int'(eh));
      chk($sformatf("R5 vec%0d reset pulses", i), rst_pulses, 1);
      chk($sformatf("R9 vec%0d reset width", i), rst_len, rw_eff);
      if (eh == 0) begin
        chk($sformatf("R4 vec%0d reset start", i), rst_start, trig_cyc + 1);
      end else begin
        chk($sformatf("R1 vec%0d first hold timing", i),
            (eh > 1) ? last_rise - 20 * (int'(eh) - 1) : last_rise, trig_cyc + 1);
        chk($sformatf("R9 vec%0d reset follows final conversion", i), rst_start, done_cyc + 1);
        chk($sformatf("R2 R3 R5 R8 vec%0d cause", i), int'(last_word[25:24]), int'(ec));
        chk($sformatf("R10 vec%0d channel id", i), int'(last_word[31:26]), 5);
        chk($sformatf("R10 vec%0d timestamp", i), int'(last_word[23:8]), int'(last_ts));
        chk($sformatf("R7 vec%0d last code", i), int'(last_word[7:0]),
            int'(code_of(int'(eh) - 1, int'(fl))));
        if (eh > 1) chk($sformatf("R6 vec%0d sample spacing", i), last_rise - prev_rise, 20);
      end
    end

    // R10: stall while buffer not ready
    mode = 2'b01; n_samples = 4'd2; rst_width = 4'd1;
    clr_mon(0);
    @(posedge clk); #1; word_ready = 1'b0;
    fire(4'b0001);
    repeat (6) @(posedge clk);
    #1; snap = word_data;
    repeat (54) @(posedge clk);
    #1;
    chk("R10 stall holds only one sample", holds, 1);
    chk("R10 stall word still valid", int'(word_valid), 1);
    chk("R10 stall word stable", int'(word_data == snap), 1);
    word_ready = 1'b1;
    repeat (80) @(posedge clk);
    #1;
    chk("R10 resume second sample", holds, 2);
    chk("R10 resume words delivered", words, 2);

    // R11: triggers mid-sequence ignored
    clr_mon(0);
    fire(4'b0001);
    repeat (8) @(posedge clk);
    fire(4'b1010);
    repeat (80) @(posedge clk);
    #1;
    chk("R11 holds unchanged by mid triggers", holds, 2);
    chk("R11 cause unchanged", int'(last_word[25:24]), 0);
    chk("R11 single reset pulse", rst_pulses, 1);

    // R12: disabled channel
    mode = 2'b00;
    clr_mon(0);
    @(posedge clk); #1; chan_en = 1'b0;
    @(posedge clk); #1;
    chk("R12 fe_reset held when disabled", int'(fe_reset), 1);
    fire(4'b0111);
    repeat (30) @(posedge clk);
    #1;
    chk("R12 no sample when disabled", holds, 0);
    chk("R12 no word when disabled", words, 0);
    chk("R12 fe_reset still held", int'(fe_reset), 1);
    chan_en = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R12 fe_reset released on enable", int'(fe_reset), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule